// File: doc/BRIEF.md
# Cascadable first-word-fall-through FIFO chain

This block is a deep queue made of several identical first-word-fall-through FIFO stages placed in series on one clock. Each stage passes its output word straight into the next stage's input. The stages pace each other through two active-low flags: an output-ready flag says that a word is showing at a stage's output, and an input-ready flag says that a stage has room. A stage's output-ready drives the next stage's write enable. The next stage's input-ready drives this stage's read enable. No glue logic sits between the stages.

The outer interface is the write port of the first stage and the read port of the last stage. A word written into an empty chain moves down to the last stage without any read request and waits there. A slot freed at the tail of a full chain moves back up to the head by itself. Both movements take a fixed number of cycles per stage. Total capacity is the stage count times the per-stage depth.

Each stage runs two small state machines. The input machine has states `IN_OPEN` (input-ready low) and `IN_FULL` (input-ready high). Its transitions are open→full, taken when the write-side occupancy count reaches the depth, and full→open, taken when it falls below the depth. The output machine has states `OUT_EMPTY` (output-ready high) and `OUT_READY` (output-ready low). Its transitions are empty→ready, taken when the read-side word count becomes non-zero, and ready→empty, taken when it returns to zero. A write becomes visible to the read side three clock edges after it is taken. A read becomes visible to the write side two edges after it is taken.

Top module: `cascade_fifo_chain`

## Requirements
- R1: The chain accepts exactly STAGES × STAGE_DEPTH words before `in_ready_n` stays high, as long as nothing is read.
- R2: Words leave `rd_data` in the order they were written, across all stages.
- R3: In an empty chain, `out_ready_n` goes low exactly (STAGES−1)×4+3 clock edges after the edge that takes a write, with no read requested.
- R4: In a full chain, `in_ready_n` goes low exactly (STAGES−1)×3+2 clock edges after the edge that takes a read from the tail.
- R5: With back-to-back writes into an empty chain and `rd_en_n` held low, word i is shown at the output after edge (STAGES−1)×4+3+i, counted from the edge of the first write. Only the first word pays the ripple delay.
- R6: A write presented while `in_ready_n` is high is ignored, and that word never reaches the output.
- R7: A read requested while `out_ready_n` is high changes nothing. A word written afterwards still ripples with the R3 latency and arrives intact.
- R8: While `out_ready_n` is low and `rd_en_n` is high, `rd_data` and `out_ready_n` hold their values.
- R9: After reset, `in_ready_n` is low and `out_ready_n` is high.
- R10: A read and a write presented on the same edge to a full chain pop the head word and drop the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; also the transfer clock between stages |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_n | input | 1 | Active-low write request to the first stage |
| wr_data | input | WIDTH | Word to write |
| in_ready_n | output | 1 | Active-low: the first stage has a free location |
| rd_en_n | input | 1 | Active-low read request to the last stage |
| rd_data | output | WIDTH | Word at the head of the queue (valid while `out_ready_n` is low) |
| out_ready_n | output | 1 | Active-low: a word is showing on `rd_data` |

## Verification
The case hardest to reach from the ports is the bubble in a chain that is truly full. Every stage must hold its full depth, and the internal counts must have settled, before one read at the tail starts the measurement. The stimulus writes whenever `in_ready_n` is low and then waits for a long run of idle cycles before it applies the combined read and write. The bench then counts edges until `in_ready_n` falls. The same sweep, covering ripple, fill, bubble, drain and streaming, runs on three instances with one, two and three stages, so that the per-stage latency terms are checked for each N.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;

    // Edges from an accepted write until the read side counts it.
    localparam int WR_VISIBLE_LAG = 3;
    // Edges from an accepted read until the write side counts the slot free.
    localparam int RD_VISIBLE_LAG = 2;

    typedef enum logic {
        IN_OPEN,
        IN_FULL
    } in_state_e;

    typedef enum logic {
        OUT_EMPTY,
        OUT_READY
    } out_state_e;

endpackage

// File: rtl/pulse_delay.sv
module pulse_delay #(
    parameter int LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    output logic pulse_out
);

    logic [LEN-1:0] shift_q;

    generate
        if (LEN == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shift_q <= '0;
                else        shift_q <= pulse_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shift_q <= '0;
                else        shift_q <= {shift_q[LEN-2:0], pulse_in};
            end
        end
    endgenerate

    assign pulse_out = shift_q[LEN-1];

endmodule

// File: rtl/fifo_chain_stage.sv
module fifo_chain_stage
    import fifo_chain_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wen_n,
    input  logic [WIDTH-1:0] din,
    output logic             ir_n,
    input  logic             ren_n,
    output logic [WIDTH-1:0] dout,
    output logic             or_n
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    wr_used, wr_used_nxt;
    logic [CW-1:0]    rd_avail, rd_avail_nxt;
    in_state_e        in_state, in_state_nxt;
    out_state_e       out_state, out_state_nxt;

    logic do_wr, do_rd;
    logic wr_seen, rd_seen;

    assign do_wr = !wen_n && !ir_n;
    assign do_rd = !ren_n && !or_n;

    pulse_delay #(.LEN(WR_VISIBLE_LAG)) u_wr_lag (
        .clk(clk), .rst_n(rst_n), .pulse_in(do_wr), .pulse_out(wr_seen)
    );

    pulse_delay #(.LEN(RD_VISIBLE_LAG)) u_rd_lag (
        .clk(clk), .rst_n(rst_n), .pulse_in(do_rd), .pulse_out(rd_seen)
    );

    // Write side counts its own writes at once and reads late; read side the opposite.
    always_comb begin
        wr_used_nxt  = wr_used + CW'(do_wr) - CW'(rd_seen);
        rd_avail_nxt = rd_avail + CW'(wr_seen) - CW'(do_rd);
    end

    always_comb begin
        in_state_nxt = in_state;
        unique case (in_state)
            IN_OPEN: if (wr_used_nxt == FULL_CNT) in_state_nxt = IN_FULL;
            IN_FULL: if (wr_used_nxt != FULL_CNT) in_state_nxt = IN_OPEN;
            default: in_state_nxt = IN_OPEN;
        endcase
    end

    always_comb begin
        out_state_nxt = out_state;
        unique case (out_state)
            OUT_EMPTY: if (rd_avail_nxt != '0) out_state_nxt = OUT_READY;
            OUT_READY: if (rd_avail_nxt == '0) out_state_nxt = OUT_EMPTY;
            default:   out_state_nxt = OUT_EMPTY;
        endcase
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_state  <= IN_OPEN;
            out_state <= OUT_EMPTY;
            wr_used   <= '0;
            rd_avail  <= '0;
            wptr      <= '0;
            rptr      <= '0;
        end else begin
            in_state  <= in_state_nxt;
            out_state <= out_state_nxt;
            wr_used   <= wr_used_nxt;
            rd_avail  <= rd_avail_nxt;
            if (do_wr) wptr <= (wptr == LAST_SLOT) ? '0 : wptr + AW'(1);
            if (do_rd) rptr <= (rptr == LAST_SLOT) ? '0 : rptr + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= din;
    end

    // Output process.
    always_comb begin
        ir_n = (in_state == IN_FULL);
        or_n = (out_state != OUT_READY);
        dout = mem[rptr];
    end

    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_used <= FULL_CNT);

    a_r2_read_view_lags: assert property (@(posedge clk) disable iff (!rst_n)
        rd_avail <= wr_used);

    a_r3_ripple_step: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(or_n) |-> $past(do_wr, 4));

    a_r4_bubble_step: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ir_n) |-> $past(do_rd, 3));

    a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        (!or_n && ren_n) |=> (!or_n && $stable(dout)));

endmodule

// File: rtl/cascade_fifo_chain.sv
module cascade_fifo_chain #(
    parameter int WIDTH       = 8,
    parameter int STAGE_DEPTH = 8,
    parameter int STAGES      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_n,
    input  logic [WIDTH-1:0] wr_data,
    output logic             in_ready_n,
    input  logic             rd_en_n,
    output logic [WIDTH-1:0] rd_data,
    output logic             out_ready_n
);

    localparam int LAST = STAGES - 1;

    logic             st_ir_n [STAGES];
    logic             st_or_n [STAGES];
    logic [WIDTH-1:0] st_dout [STAGES];

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            logic             link_wen_n;
            logic [WIDTH-1:0] link_din;
            logic             link_ren_n;

            if (k == 0) begin : g_head
                assign link_wen_n = wr_en_n;
                assign link_din   = wr_data;
            end else begin : g_body_in
                assign link_wen_n = st_or_n[k-1];
                assign link_din   = st_dout[k-1];
            end

            if (k == LAST) begin : g_tail
                assign link_ren_n = rd_en_n;
            end else begin : g_body_out
                assign link_ren_n = st_ir_n[k+1];
            end

            fifo_chain_stage #(.WIDTH(WIDTH), .DEPTH(STAGE_DEPTH)) u_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .wen_n (link_wen_n),
                .din   (link_din),
                .ir_n  (st_ir_n[k]),
                .ren_n (link_ren_n),
                .dout  (st_dout[k]),
                .or_n  (st_or_n[k])
            );
        end
    endgenerate

    assign in_ready_n  = st_ir_n[0];
    assign out_ready_n = st_or_n[LAST];
    assign rd_data     = st_dout[LAST];

    a_r6_refused_write_no_head_change: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready_n && !wr_en_n && rd_en_n && !out_ready_n) |=> $stable(rd_data));

endmodule

// File: tb/cascade_fifo_chain_bench.sv
module cascade_fifo_chain_bench;

    localparam int W = 8;
    localparam int D = 8;
    localparam int NMAX = 3;
    localparam int STREAM_LEN = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic         wen_n [1:NMAX];
    logic [W-1:0] wdat  [1:NMAX];
    logic         ren_n [1:NMAX];
    logic         ir_n  [1:NMAX];
    logic         or_n  [1:NMAX];
    logic [W-1:0] rdat  [1:NMAX];

    int n_chk = 0;
    int n_fail = 0;
    int q[$];

    always #4 clk = ~clk;

    generate
        for (genvar g = 1; g <= NMAX; g++) begin : g_cfg
            cascade_fifo_chain #(.WIDTH(W), .STAGE_DEPTH(D), .STAGES(g)) u_cascade_fifo_chain (
                .clk(clk), .rst_n(rst_n),
                .wr_en_n(wen_n[g]), .wr_data(wdat[g]), .in_ready_n(ir_n[g]),
                .rd_en_n(ren_n[g]), .rd_data(rdat[g]), .out_ready_n(or_n[g])
            );
        end
    endgenerate

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual cycles 60000 expected fewer");
        report();
        $finish;
    end

    task automatic run_cfg(input int g);
        int lat_r, lat_b, k, cnt, idle, v, got;
        lat_r = (g - 1) * 4 + 3;
        lat_b = (g - 1) * 3 + 2;
        q.delete();

        // R9: reset state
        chk(ir_n[g] == 1'b0, "R9 in_ready_n after reset", int'(ir_n[g]), 0);
        chk(or_n[g] == 1'b1, "R9 out_ready_n after reset", int'(or_n[g]), 1);

        // R7: reads on an empty chain
        @(negedge clk); ren_n[g] = 1'b0;
        repeat (4) @(negedge clk);
        ren_n[g] = 1'b1;
        chk(or_n[g] == 1'b1, "R7 empty read leaves output idle", int'(or_n[g]), 1);

        // R3: ripple latency of the first word
        v = 8'h40 + g;
        wen_n[g] = 1'b0; wdat[g] = W'(v);
        k = 0;
        got = -1;
        while (k < lat_r + 10 && got < 0) begin
            @(negedge clk);
            if (k == 0) wen_n[g] = 1'b1;
            if (!or_n[g]) got = k;
            k++;
        end
        chk(got == lat_r, "R3 ripple edges", got, lat_r);
        chk(int'(rdat[g]) == v, "R7 word after empty reads", int'(rdat[g]), v);

        // R8: output holds without a read
        repeat (8) @(negedge clk);
        chk(!or_n[g] && int'(rdat[g]) == v, "R8 output held", int'(rdat[g]), v);

        // pop it
        ren_n[g] = 1'b0;
        @(negedge clk); ren_n[g] = 1'b1;
        repeat (10) @(negedge clk);
        chk(or_n[g] == 1'b1, "R2 chain empty after single pop", int'(or_n[g]), 1);

        // R1: fill to capacity
        cnt = 0; idle = 0;
        while (idle < 40) begin
            @(negedge clk);
            if (!ir_n[g]) begin
                v = (g << 5) + cnt;
                wen_n[g] = 1'b0; wdat[g] = W'(v);
                q.push_back(v);
                cnt++; idle = 0;
            end else begin
                wen_n[g] = 1'b1;
                idle++;
            end
        end
        chk(cnt == g * D, "R1 capacity", cnt, g * D);

        // R10 / R6: read and write together on a full chain
        chk(ir_n[g] == 1'b1, "R10 chain reports full", int'(ir_n[g]), 1);
        v = q.pop_front();
        chk(int'(rdat[g]) == v, "R10 head word", int'(rdat[g]), v);
        wen_n[g] = 1'b0; wdat[g] = 8'hEE; ren_n[g] = 1'b0;

        // R4: bubble latency
        k = 0; got = -1;
        while (k < lat_b + 10 && got < 0) begin
            @(negedge clk);
            if (k == 0) begin wen_n[g] = 1'b1; ren_n[g] = 1'b1; end
            if (!ir_n[g]) got = k;
            k++;
        end
        chk(got == lat_b, "R4 bubble edges", got, lat_b);
        repeat (10) @(negedge clk);

        // R2 / R6: drain, dropped word must not appear
        k = 0;
        while (q.size() > 0 && k < 400) begin
            @(negedge clk);
            if (!or_n[g]) begin
                v = q.pop_front();
                chk(int'(rdat[g]) == v, "R2 drain order", int'(rdat[g]), v);
                ren_n[g] = 1'b0;
            end else begin
                ren_n[g] = 1'b1;
            end
            k++;
        end
        @(negedge clk); ren_n[g] = 1'b1;
        repeat (12) @(negedge clk);
        chk(or_n[g] == 1'b1, "R6 no extra word after drain", int'(or_n[g]), 1);

        // R5: streaming with reader always enabled
        ren_n[g] = 1'b0;
        wen_n[g] = 1'b0; wdat[g] = W'(8'h80);
        got = 0;
        for (int e = 0; e < lat_r + STREAM_LEN + 8; e++) begin
            @(negedge clk);
            if (!or_n[g]) begin
                chk(e == lat_r + got, "R5 stream arrival edge", e, lat_r + got);
                chk(int'(rdat[g]) == 8'h80 + got, "R5 stream data", int'(rdat[g]), 8'h80 + got);
                got++;
            end
            if (e + 1 < STREAM_LEN) begin
                wen_n[g] = 1'b0; wdat[g] = W'(8'h80 + e + 1);
            end else begin
                wen_n[g] = 1'b1;
            end
        end
        chk(got == STREAM_LEN, "R5 stream count", got, STREAM_LEN);
        ren_n[g] = 1'b1;
    endtask

    initial begin
        for (int g = 1; g <= NMAX; g++) begin
            wen_n[g] = 1'b1; ren_n[g] = 1'b1; wdat[g] = '0;
        end
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int g = 1; g <= NMAX; g++) begin
            run_cfg(g);
        end
        report();
        $finish;
    end

endmodule